// File: doc/BRIEF.md
# Frame-Level CCD Sequence Controller

This controller runs the frame cycle of a frame-transfer area sensor. A frame trigger starts an exposure slot. The slot can open with an electronic-shutter drain interval. During that interval the image-zone phases are parked low and the antiblooming gate is pulsed, so photo-charge is dumped into the drain. Integration follows, with the antiblooming gate held high. When the slot ends, the controller asks an external vertical-transfer generator for one burst that moves the whole image into the masked memory zone, and waits for it to report completion.

The memory zone is then read out line by line while the next exposure is already running. For each output line, the controller first asks a line-shift child to move one memory line into the serial register. In 2x2 binning mode it asks for two shifts. It then asks a line-readout child to clock that line out. Each output line carries its memory line index and a two-bit class derived from the fixed 1056-line layout. That layout, in order of readout, is: 1 dummy, 12 shielded dark, 3 isolation, 1024 useful, 3 isolation, 12 dark, 1 dummy.

The exposure slot length and the shutter length are taken from register inputs when a trigger is accepted. A trigger that arrives while an exposure slot is still running is dropped and raises a sticky error flag.

Top module: `ccd_frame_seq`

## Requirements
- R1: After a cycle with `rst` high, the outputs are `ab_gate`=0, `img_drain`=0, `xfer_req`=0, `mem_req`=0, `line_req`=0 and `trig_err`=0, and the controller waits for a trigger.
- R2: When a trigger is accepted with an effective shutter length S>0, `img_drain` is high for exactly S cycles, starting in the cycle after the trigger edge. During those cycles `ab_gate` alternates, beginning high.
- R3: Integration follows the shutter. It lasts P-S cycles with `ab_gate`=1 and `img_drain`=0, where P is `frame_period` (0 is treated as 1). A shutter length of 0 gives integration over all P cycles. A shutter length of at least P is cut to P-1.
- R4: After integration, `ab_gate` is 0 and `xfer_req` is raised. `xfer_req` stays high until `xfer_done` is seen with it.
- R5: After the transfer completes, each output line is produced in two steps. First `mem_req` is held until `mem_done`, then `line_req` is held until `line_done`. While `line_req` is high, `line_num` shows the memory line index, starting at 0. Without binning, 1056 lines are produced per frame.
- R6: `line_type` codes are: dummy=0, dark reference=1, isolation=2, useful=3. They follow the layout: index 0 dummy, 1–12 dark, 13–15 isolation, 16–1039 useful, 1040–1042 isolation, 1043–1054 dark, 1055 dummy.
- R7: With `bin_en` sampled high at transfer completion, each output line takes two `mem_done` handshakes and `line_num` steps by 2. This gives 528 lines, of which 512 are useful. A pair's class is the lower code of its two memory lines.
- R8: A trigger that arrives while an exposure slot is in progress is ignored and sets `trig_err`. The flag stays set until reset.
- R9: A trigger is accepted while the previous frame's memory readout is still running. `xfer_req` is withheld until that readout has finished.
- R10: `mem_req` and `line_req` are never high together. A `mem_done`, `line_done` or `xfer_done` that arrives while its request is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_trig | input | 1 | Starts an exposure slot |
| frame_period | input | TMR_W | Exposure slot length in clocks |
| shutter_len | input | TMR_W | Drain interval length in clocks, 0 = off |
| bin_en | input | 1 | 2x2 binning for the frame being transferred |
| ab_gate | output | 1 | Antiblooming gate drive |
| img_drain | output | 1 | Image-zone phases parked low for draining |
| xfer_req | output | 1 | Image-to-memory burst request |
| xfer_done | input | 1 | Burst finished |
| mem_req | output | 1 | Shift one memory line into the serial register |
| mem_done | input | 1 | Line shift finished |
| line_req | output | 1 | Read out the serial register |
| line_done | input | 1 | Line readout finished |
| line_num | output | LINE_W | Memory line index of the current line |
| line_type | output | 2 | Class of the current line |
| trig_err | output | 1 | Sticky early-trigger flag |

## Verification
The bench builds the block with its default geometry, so it checks the true 1056-line layout: every class boundary, the 528-line binned frame and its mixed-class pairs. Timer widths are left at default, but the bench programs short exposure slots of 10 to 30 clocks. This keeps whole frames, the overlap of a new exposure with an ongoing readout, and the clamp of an oversized shutter within a short run.

// File: rtl/ccd_frame_seq.sv
module ccd_frame_seq #(
  parameter int DUMMY_N  = 1,
  parameter int DARK_N   = 12,
  parameter int ISO_N    = 3,
  parameter int USEFUL_N = 1024,
  parameter int TMR_W    = 16,
  localparam int LINES   = 2 * (DUMMY_N + DARK_N + ISO_N) + USEFUL_N,
  localparam int LINE_W  = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_trig,
  input  logic [TMR_W-1:0]  frame_period,
  input  logic [TMR_W-1:0]  shutter_len,
  input  logic              bin_en,
  output logic              ab_gate,
  output logic              img_drain,
  output logic              xfer_req,
  input  logic              xfer_done,
  output logic              mem_req,
  input  logic              mem_done,
  output logic              line_req,
  input  logic              line_done,
  output logic [LINE_W-1:0] line_num,
  output logic [1:0]        line_type,
  output logic              trig_err
);

  localparam int B_DARK  = DUMMY_N;
  localparam int B_ISO   = B_DARK + DARK_N;
  localparam int B_USE   = B_ISO + ISO_N;
  localparam int B_ISO2  = B_USE + USEFUL_N;
  localparam int B_DARK2 = B_ISO2 + ISO_N;
  localparam int B_DUM2  = B_DARK2 + DARK_N;

  typedef enum logic [1:0] {E_IDLE, E_SHUT, E_INTEG, E_XFER} exp_t;
  typedef enum logic [1:0] {R_IDLE, R_MEM, R_LINE} rd_t;

  exp_t             es;
  rd_t              rs;
  logic [TMR_W-1:0] tmr, int_len, p_eff, s_eff;
  logic             ph, half, binl, xfer_go;
  logic [LINE_W-1:0] idx;
  logic [LINE_W:0]  nxt;
  logic [1:0]       k0, k1;

  function automatic logic [1:0] kind(input int i);
    if (i < B_DARK)       return 2'd0;
    else if (i < B_ISO)   return 2'd1;
    else if (i < B_USE)   return 2'd2;
    else if (i < B_ISO2)  return 2'd3;
    else if (i < B_DARK2) return 2'd2;
    else if (i < B_DUM2)  return 2'd1;
    else                  return 2'd0;
  endfunction

  assign p_eff   = (frame_period == '0) ? TMR_W'(1) : frame_period;
  assign s_eff   = (shutter_len >= p_eff) ? p_eff - TMR_W'(1) : shutter_len;
  assign xfer_go = (es == E_XFER) && (rs == R_IDLE) && xfer_done;
  assign nxt     = {1'b0, idx} + (binl ? (LINE_W+1)'(2) : (LINE_W+1)'(1));

  assign k0 = kind(int'(idx));
  assign k1 = kind(int'(idx) + 1);

  assign ab_gate   = (es == E_SHUT) ? ph : (es == E_INTEG);
  assign img_drain = (es == E_SHUT);
  assign xfer_req  = (es == E_XFER) && (rs == R_IDLE);
  assign mem_req   = (rs == R_MEM);
  assign line_req  = (rs == R_LINE);
  assign line_num  = idx;
  assign line_type = (binl && k1 < k0) ? k1 : k0;

  always_ff @(posedge clk) begin
    if (rst) begin
      es      <= E_IDLE;
      tmr     <= '0;
      int_len <= '0;
      ph      <= 1'b0;
      trig_err <= 1'b0;
    end else begin
      if (frame_trig && es != E_IDLE) trig_err <= 1'b1;
      case (es)
        E_IDLE: if (frame_trig) begin
          int_len <= p_eff - s_eff;
          ph      <= 1'b1;
          if (s_eff != '0) begin
            es  <= E_SHUT;
            tmr <= s_eff - TMR_W'(1);
          end else begin
            es  <= E_INTEG;
            tmr <= p_eff - TMR_W'(1);
          end
        end
        E_SHUT: begin
          ph <= ~ph;
          if (tmr == '0) begin
            es  <= E_INTEG;
            tmr <= int_len - TMR_W'(1);
          end else tmr <= tmr - TMR_W'(1);
        end
        E_INTEG: begin
          if (tmr == '0) es <= E_XFER;
          else tmr <= tmr - TMR_W'(1);
        end
        default: if (xfer_go) es <= E_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rs   <= R_IDLE;
      idx  <= '0;
      half <= 1'b0;
      binl <= 1'b0;
    end else begin
      case (rs)
        R_IDLE: if (xfer_go) begin
          rs   <= R_MEM;
          idx  <= '0;
          half <= 1'b0;
          binl <= bin_en;
        end
        R_MEM: if (mem_done) begin
          if (binl && !half) half <= 1'b1;
          else rs <= R_LINE;
        end
        default: if (line_done) begin
          half <= 1'b0;
          if (nxt >= (LINE_W+1)'(LINES)) begin
            rs  <= R_IDLE;
            idx <= '0;
          end else begin
            rs  <= R_MEM;
            idx <= nxt[LINE_W-1:0];
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/ccd_frame_seq_chk.sv
module ccd_frame_seq_chk #(
  parameter int LINE_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              ab_gate,
  input logic              img_drain,
  input logic              xfer_req,
  input logic              xfer_done,
  input logic              mem_req,
  input logic              line_req,
  input logic              line_done,
  input logic [LINE_W-1:0] line_num,
  input logic [1:0]        line_type,
  input logic              trig_err
);

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!ab_gate && !img_drain && !xfer_req && !mem_req && !line_req && !trig_err));

  p_shut_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    (img_drain && $past(img_drain)) |-> (ab_gate != $past(ab_gate)));

  p_drain_no_xfer_r2: assert property (@(posedge clk) disable iff (rst)
    img_drain |-> !xfer_req);

  p_xfer_ab_low_r4: assert property (@(posedge clk) disable iff (rst)
    xfer_req |-> !ab_gate);

  p_xfer_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !xfer_done) |=> xfer_req);

  p_line_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (line_req && !line_done) |=> (line_req && $stable(line_num) && $stable(line_type)));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    trig_err |=> trig_err);

  p_xfer_after_read_r9: assert property (@(posedge clk) disable iff (rst)
    xfer_req |-> (!mem_req && !line_req));

  p_req_excl_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_req, line_req}));

endmodule

bind ccd_frame_seq ccd_frame_seq_chk #(.LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst(rst), .ab_gate(ab_gate), .img_drain(img_drain),
  .xfer_req(xfer_req), .xfer_done(xfer_done), .mem_req(mem_req),
  .line_req(line_req), .line_done(line_done), .line_num(line_num),
  .line_type(line_type), .trig_err(trig_err)
);

// File: tb/ccd_frame_seq_tb.sv
module ccd_frame_seq_tb;
  localparam int TW = 16;
  localparam int NL = 1056;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_trig = 1'b0;
  logic [TW-1:0] frame_period = '0;
  logic [TW-1:0] shutter_len = '0;
  logic bin_en = 1'b0;
  logic xfer_done = 1'b0, mem_done = 1'b0, line_done = 1'b0;
  logic ab_gate, img_drain, xfer_req, mem_req, line_req, trig_err;
  logic [10:0] line_num;
  logic [1:0] line_type;

  always #5 clk = ~clk;

  ccd_frame_seq u_dut (
    .clk(clk), .rst(rst), .frame_trig(frame_trig), .frame_period(frame_period),
    .shutter_len(shutter_len), .bin_en(bin_en), .ab_gate(ab_gate),
    .img_drain(img_drain), .xfer_req(xfer_req), .xfer_done(xfer_done),
    .mem_req(mem_req), .mem_done(mem_done), .line_req(line_req),
    .line_done(line_done), .line_num(line_num), .line_type(line_type),
    .trig_err(trig_err)
  );

  int n_cmp = 0, n_bad = 0;
  bit started = 0, stray = 0, done_flag = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic int cls(input int i);
    if (i < 1) return 0;
    if (i < 13) return 1;
    if (i < 16) return 2;
    if (i < 1040) return 3;
    if (i < 1043) return 2;
    if (i < 1055) return 1;
    return 0;
  endfunction

  // behavioural reference model
  int es = 0, rs = 0, cnt = 0, el = 0, pe = 0, se = 0, idx = 0, half = 0, binl = 0, err = 0;

  always @(posedge clk) begin
    int go, st;
    started = 1;
    if (rst) begin
      es = 0; rs = 0; cnt = 0; el = 0; idx = 0; half = 0; binl = 0; err = 0;
    end else begin
      go = (es == 3 && rs == 0 && xfer_done) ? 1 : 0;
      case (rs)
        0: if (go) begin rs = 1; idx = 0; half = 0; binl = bin_en; end
        1: if (mem_done) begin
             if (binl && !half) half = 1; else rs = 2;
           end
        default: if (line_done) begin
             st = binl ? 2 : 1;
             half = 0;
             if (idx + st >= NL) begin rs = 0; idx = 0; end
             else begin idx += st; rs = 1; end
           end
      endcase
      if (frame_trig && es != 0) err = 1;
      case (es)
        0: if (frame_trig) begin
             pe = (frame_period == 0) ? 1 : int'(frame_period);
             se = (int'(shutter_len) >= pe) ? pe - 1 : int'(shutter_len);
             el = 0;
             if (se > 0) begin es = 1; cnt = se; end
             else begin es = 2; cnt = pe; end
           end
        1: begin el++; cnt--; if (cnt == 0) begin es = 2; cnt = pe - se; end end
        2: begin cnt--; if (cnt == 0) es = 3; end
        default: if (go) es = 0;
      endcase
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    int eab, et;
    if (started && !done_flag) begin
      eab = (es == 1) ? ((el % 2 == 0) ? 1 : 0) : ((es == 2) ? 1 : 0);
      if (es == 1) chk("R2", "ab_gate shutter", ab_gate, eab);
      else chk("R3", "ab_gate", ab_gate, eab);
      chk("R2", "img_drain", img_drain, es == 1);
      chk("R4", "xfer_req", xfer_req, (es == 3 && rs == 0));
      chk("R5", "mem_req", mem_req, rs == 1);
      chk("R10", "line_req", line_req, rs == 2);
      chk("R8", "trig_err", trig_err, err);
      if (rs == 2) begin
        chk("R5", "line_num", line_num, idx);
        if (binl) begin
          et = cls(idx) < cls(idx + 1) ? cls(idx) : cls(idx + 1);
          chk("R7", "line_type pair", line_type, et);
        end else chk("R6", "line_type", line_type, cls(idx));
      end
    end
  end

  // child responders
  int mc = 0, lc = 0, xc = 0;
  int frames = 0, nlines = 0, nuse = 0;
  int f_lines[4], f_use[4];

  always @(negedge clk) begin
    if (stray) begin
      stray = 0;
      mem_done = 1; line_done = 1; xfer_done = 1;
    end else begin
      xfer_done = 0;
      if (xfer_req) begin xc++; if (xc >= 4) begin xfer_done = 1; xc = 0; end end
      else xc = 0;
      if (mem_done) begin mem_done = 0; mc = 0; end
      else if (mem_req) begin mc++; if (mc >= 2) mem_done = 1; end
      else mc = 0;
      if (line_done) begin line_done = 0; lc = 0; end
      else if (line_req) begin
        lc++;
        if (lc >= 3) begin
          line_done = 1;
          nlines++;
          if (line_type == 2'd3) nuse++;
          if (int'(line_num) >= NL - 2 && (nlines == NL || nlines == NL / 2)) begin
            if (frames < 4) begin f_lines[frames] = nlines; f_use[frames] = nuse; end
            frames++; nlines = 0; nuse = 0;
          end
        end
      end else lc = 0;
    end
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic trig();
    frame_trig = 1;
    @(negedge clk);
    frame_trig = 0;
  endtask

  initial begin
    ticks(3);
    rst = 0;
    // R1: reset state at the ports
    chk("R1", "ab_gate after reset", ab_gate, 0);
    chk("R1", "img_drain after reset", img_drain, 0);
    chk("R1", "requests after reset", {xfer_req, mem_req, line_req}, 0);
    chk("R1", "trig_err after reset", trig_err, 0);
    // R10: stray done pulses while nothing is requested
    stray = 1;
    ticks(3);
    chk("R10", "idle after stray done", {ab_gate, xfer_req, mem_req, line_req}, 0);

    // frame A: shutter 6 of 20, no binning
    frame_period = 20; shutter_len = 6; bin_en = 0;
    trig();
    while (!mem_req) @(negedge clk);
    // R9: frame B triggered during readout of A, no shutter
    ticks(40);
    frame_period = 30; shutter_len = 0;
    trig();
    ticks(5);
    // R8: early trigger during B's exposure
    trig();
    chk("R8", "flag after early trigger", trig_err, 1);
    ticks(40);
    chk("R9", "transfer held while reading", xfer_req, 0);
    while (frames < 2) @(negedge clk);

    // frame C: binning, shutter beyond slot (clamped)
    frame_period = 10; shutter_len = 50; bin_en = 1;
    trig();
    while (frames < 3) @(negedge clk);
    ticks(20);

    chk("R5", "lines in frame A", f_lines[0], NL);
    chk("R6", "useful lines in frame A", f_use[0], 1024);
    chk("R5", "lines in frame B", f_lines[1], NL);
    chk("R7", "binned lines", f_lines[2], NL / 2);
    chk("R7", "binned useful lines", f_use[2], 512);
    chk("R8", "flag still set", trig_err, 1);
    chk("R1", "back to idle", {ab_gate, img_drain, xfer_req, mem_req, line_req}, 0);
    finish_run();
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <= 150000 cycles", wd);
      finish_run();
    end
  end

endmodule